// File: doc/BRIEF.md
# Dual-Client Display Timing Generator

This block derives the raster timing for a 256x192 screen from the system clock. A cascade of counters splits each dot into a fixed number of clocks, each scanline into a draw span followed by a horizontal blank span, and each frame into visible lines followed by blanking lines. From these counters it keeps the horizontal and vertical blank flags. It also emits single-cycle strobes to the surrounding logic: interrupt requests, DMA triggers and a toggle of the front/back frame-buffer bank.

Two processors each get their own status and control set on top of one shared timing counter. Each set holds a line-compare value and three interrupt enables, keeps its own line-coincidence flag, and drives its own interrupt lines. Both sets report the same line number and the same blank flags. Renderers, DMA engines, interrupt controllers and memories sit outside and only consume the outputs.

Top module: `disp_timing_gen`

## Requirements
- R1: The dot position `dot_x` advances by one every `CLKS_PER_DOT` clocks and counts 0 up to `DRAW_DOTS+BLANK_DOTS-1`, then returns to 0.
- R2: The horizontal blank flag (bit 0 of each client's status group) rises when `dot_x` becomes `DRAW_DOTS` and falls when `dot_x` returns to 0, in the same cycle that `line_y` advances.
- R3: `line_y` advances by one each time `dot_x` wraps, counting 0 to `FRAME_LINES-1` and then wrapping to 0.
- R4: The vertical blank flag (bit 1 of each status group) rises when `line_y` becomes `ACTIVE_LINES` and falls when `line_y` becomes `FRAME_LINES-1`.
- R5: Each time `line_y` advances, each client's coincidence flag (bit 2 of its status group) takes the result of comparing the new line with that client's stored compare value, and holds it until the next advance.
- R6: When a client's coincidence result is true at a line advance and its line-match enable (enable bit 2) is set, its `irq_match` bit pulses for one cycle, together with the flag update.
- R7: When the horizontal blank flag rises, each client with its hblank enable (enable bit 0) set pulses its `irq_hblank` bit for one cycle, on visible and blanking lines alike.
- R8: When the vertical blank flag rises, each client with its vblank enable (enable bit 1) set pulses its `irq_vblank` bit for one cycle.
- R9: `dma_hblank_stb` pulses for one cycle at each horizontal blank start, but only when the vertical blank flag is clear.
- R10: `dma_vblank_stb` pulses for one cycle and `fb_bank` inverts when `line_y` becomes `ACTIVE_LINES`; `fb_bank` changes at no other time.
- R11: While `rst` is high, and in the first cycle after reset, all counters, flags, strobes and `fb_bank` are 0, and all stored enables and compare values are 0.
- R12: A write with `cfg_we[i]` high loads the compare value and enables of client i only, at the next clock edge; the other client's configuration is unchanged.
- R13: Every interrupt and DMA strobe is high for one cycle at most.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | NUM_CLIENTS | Per-client configuration write strobe |
| cfg_match | input | NUM_CLIENTS*LINE_W | Per-client line-compare value, client i in slice i*LINE_W |
| cfg_irq_en | input | NUM_CLIENTS*3 | Per-client enables: bit 0 hblank, bit 1 vblank, bit 2 line match |
| dot_x | output | DOT_W | Current dot within the line |
| line_y | output | LINE_W | Current line, shared by both clients |
| stat_flags | output | NUM_CLIENTS*3 | Per-client status: bit 0 hblank, bit 1 vblank, bit 2 coincidence |
| irq_hblank | output | NUM_CLIENTS | Horizontal blank interrupt pulse per client |
| irq_vblank | output | NUM_CLIENTS | Vertical blank interrupt pulse per client |
| irq_match | output | NUM_CLIENTS | Line-match interrupt pulse per client |
| dma_hblank_stb | output | 1 | Horizontal blank DMA trigger pulse |
| dma_vblank_stb | output | 1 | Vertical blank DMA trigger pulse |
| fb_bank | output | 1 | Frame-buffer bank select |

## Verification
The checker assumes that reset is held for at least one edge and that the geometry parameters describe a legal frame: at least two clocks per dot, `ACTIVE_LINES` below `FRAME_LINES-1`, and nonzero draw and blank spans. The properties then need nothing from the configuration inputs, because every strobe is checked against the counters and flags that it must coincide with. The bench keeps to these limits by using a compressed geometry that still meets them, and by writing random compare values only within the legal line range, with enables that toggle freely at any cycle, including on the edge of a line advance.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;

    // Per-client interrupt enables; hblank sits in bit 0.
    typedef struct packed {
        logic on_match;
        logic on_vblank;
        logic on_hblank;
    } irq_en_t;

    localparam int STAT_HBLANK = 0;
    localparam int STAT_VBLANK = 1;
    localparam int STAT_COINC  = 2;
    localparam int STAT_BITS   = 3;

    // Timing events decoded from the counters, valid in the cycle before the edge they act on.
    typedef struct packed {
        logic hb_start;
        logic line_adv;
        logic vb_enter;
        logic vb_leave;
    } tim_evt_t;

    function automatic int width_of(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/dt_dot_counter.sv
module dt_dot_counter
    import disp_timing_pkg::*;
#(
    parameter int CLKS_PER_DOT = 6,
    parameter int DRAW_DOTS    = 256,
    parameter int BLANK_DOTS   = 99,
    parameter int DOT_W        = 9
) (
    input  logic             clk,
    input  logic             rst,
    output logic [DOT_W-1:0] dot_q,
    output logic             hb_start,
    output logic             line_end
);
    localparam int TOTAL_DOTS = DRAW_DOTS + BLANK_DOTS;
    localparam int PH_W       = width_of(CLKS_PER_DOT);

    logic [PH_W-1:0] phase_q;
    logic            dot_tick;

    assign dot_tick = (phase_q == PH_W'(CLKS_PER_DOT - 1));
    assign hb_start = dot_tick && (dot_q == DOT_W'(DRAW_DOTS - 1));
    assign line_end = dot_tick && (dot_q == DOT_W'(TOTAL_DOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            dot_q   <= '0;
        end else if (dot_tick) begin
            phase_q <= '0;
            dot_q   <= line_end ? '0 : dot_q + 1'b1;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/dt_line_counter.sv
module dt_line_counter
    import disp_timing_pkg::*;
#(
    parameter int FRAME_LINES  = 263,
    parameter int ACTIVE_LINES = 192,
    parameter int LINE_W       = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hb_start,
    input  logic              line_end,
    output logic [LINE_W-1:0] line_q,
    output logic [LINE_W-1:0] next_line,
    output tim_evt_t          evt
);
    localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(FRAME_LINES - 1);
    localparam logic [LINE_W-1:0] VB_START   = LINE_W'(ACTIVE_LINES);

    assign next_line = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;

    always_comb begin
        evt.hb_start = hb_start;
        evt.line_adv = line_end;
        evt.vb_enter = line_end && (next_line == VB_START);
        evt.vb_leave = line_end && (next_line == LAST_LINE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else if (line_end) begin
            line_q <= next_line;
        end
    end
endmodule

// File: rtl/dt_frame_flags.sv
module dt_frame_flags
    import disp_timing_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tim_evt_t evt,
    output logic     hblank_q,
    output logic     vblank_q,
    output logic     dma_h_q,
    output logic     dma_v_q,
    output logic     bank_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hblank_q <= 1'b0;
            vblank_q <= 1'b0;
            dma_h_q  <= 1'b0;
            dma_v_q  <= 1'b0;
            bank_q   <= 1'b0;
        end else begin
            if (evt.hb_start) begin
                hblank_q <= 1'b1;
            end else if (evt.line_adv) begin
                hblank_q <= 1'b0;
            end

            if (evt.vb_enter) begin
                vblank_q <= 1'b1;
            end else if (evt.vb_leave) begin
                vblank_q <= 1'b0;
            end

            // Line-boundary updates never coincide with a blank start, so the old vblank is exact here.
            dma_h_q <= evt.hb_start && !vblank_q;
            dma_v_q <= evt.vb_enter;
            bank_q  <= bank_q ^ evt.vb_enter;
        end
    end
endmodule

// File: rtl/dt_client.sv
module dt_client
    import disp_timing_pkg::*;
#(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [LINE_W-1:0] wr_match,
    input  irq_en_t           wr_en,
    input  logic              hb_start,
    input  logic              line_adv,
    input  logic              vb_enter,
    input  logic [LINE_W-1:0] next_line,
    output logic              coinc_q,
    output logic              irq_h_q,
    output logic              irq_v_q,
    output logic              irq_m_q
);
    logic [LINE_W-1:0] match_q;
    irq_en_t           en_q;
    logic              hit;

    assign hit = (next_line == match_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            en_q    <= '0;
        end else if (we) begin
            match_q <= wr_match;
            en_q    <= wr_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coinc_q <= 1'b0;
            irq_h_q <= 1'b0;
            irq_v_q <= 1'b0;
            irq_m_q <= 1'b0;
        end else begin
            if (line_adv) begin
                coinc_q <= hit;
            end
            irq_h_q <= hb_start && en_q.on_hblank;
            irq_v_q <= vb_enter && en_q.on_vblank;
            irq_m_q <= line_adv && hit && en_q.on_match;
        end
    end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import disp_timing_pkg::*;
#(
    parameter int CLKS_PER_DOT = 6,
    parameter int DRAW_DOTS    = 256,
    parameter int BLANK_DOTS   = 99,
    parameter int FRAME_LINES  = 263,
    parameter int ACTIVE_LINES = 192,
    parameter int NUM_CLIENTS  = 2,
    parameter int DOT_W        = $clog2(DRAW_DOTS + BLANK_DOTS),
    parameter int LINE_W       = $clog2(FRAME_LINES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CLIENTS-1:0]          cfg_we,
    input  logic [NUM_CLIENTS*LINE_W-1:0]   cfg_match,
    input  logic [NUM_CLIENTS*3-1:0]        cfg_irq_en,
    output logic [DOT_W-1:0]                dot_x,
    output logic [LINE_W-1:0]               line_y,
    output logic [NUM_CLIENTS*3-1:0]        stat_flags,
    output logic [NUM_CLIENTS-1:0]          irq_hblank,
    output logic [NUM_CLIENTS-1:0]          irq_vblank,
    output logic [NUM_CLIENTS-1:0]          irq_match,
    output logic                            dma_hblank_stb,
    output logic                            dma_vblank_stb,
    output logic                            fb_bank
);
    logic              hb_start;
    logic              line_end;
    logic [LINE_W-1:0] next_line;
    tim_evt_t          evt;
    logic              hblank;
    logic              vblank;

    dt_dot_counter #(
        .CLKS_PER_DOT (CLKS_PER_DOT),
        .DRAW_DOTS    (DRAW_DOTS),
        .BLANK_DOTS   (BLANK_DOTS),
        .DOT_W        (DOT_W)
    ) u_dot (
        .clk      (clk),
        .rst      (rst),
        .dot_q    (dot_x),
        .hb_start (hb_start),
        .line_end (line_end)
    );

    dt_line_counter #(
        .FRAME_LINES  (FRAME_LINES),
        .ACTIVE_LINES (ACTIVE_LINES),
        .LINE_W       (LINE_W)
    ) u_line (
        .clk       (clk),
        .rst       (rst),
        .hb_start  (hb_start),
        .line_end  (line_end),
        .line_q    (line_y),
        .next_line (next_line),
        .evt       (evt)
    );

    dt_frame_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .hblank_q (hblank),
        .vblank_q (vblank),
        .dma_h_q  (dma_hblank_stb),
        .dma_v_q  (dma_vblank_stb),
        .bank_q   (fb_bank)
    );

    for (genvar ci = 0; ci < NUM_CLIENTS; ci++) begin : g_client
        logic coinc;

        dt_client #(
            .LINE_W (LINE_W)
        ) u_client (
            .clk       (clk),
            .rst       (rst),
            .we        (cfg_we[ci]),
            .wr_match  (cfg_match[ci*LINE_W +: LINE_W]),
            .wr_en     (irq_en_t'(cfg_irq_en[ci*3 +: 3])),
            .hb_start  (evt.hb_start),
            .line_adv  (evt.line_adv),
            .vb_enter  (evt.vb_enter),
            .next_line (next_line),
            .coinc_q   (coinc),
            .irq_h_q   (irq_hblank[ci]),
            .irq_v_q   (irq_vblank[ci]),
            .irq_m_q   (irq_match[ci])
        );

        assign stat_flags[ci*STAT_BITS + STAT_HBLANK] = hblank;
        assign stat_flags[ci*STAT_BITS + STAT_VBLANK] = vblank;
        assign stat_flags[ci*STAT_BITS + STAT_COINC]  = coinc;
    end
endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
    parameter int CLKS_PER_DOT = 6,
    parameter int DRAW_DOTS    = 256,
    parameter int BLANK_DOTS   = 99,
    parameter int FRAME_LINES  = 263,
    parameter int ACTIVE_LINES = 192,
    parameter int NUM_CLIENTS  = 2,
    parameter int DOT_W        = 9,
    parameter int LINE_W       = 9
) (
    input logic                        clk,
    input logic                        rst,
    input logic [DOT_W-1:0]            dot_x,
    input logic [LINE_W-1:0]           line_y,
    input logic [NUM_CLIENTS*3-1:0]    stat_flags,
    input logic [NUM_CLIENTS-1:0]      irq_hblank,
    input logic [NUM_CLIENTS-1:0]      irq_vblank,
    input logic [NUM_CLIENTS-1:0]      irq_match,
    input logic                        dma_hblank_stb,
    input logic                        dma_vblank_stb,
    input logic                        fb_bank
);
    localparam int TOTAL_DOTS = DRAW_DOTS + BLANK_DOTS;

    logic hb;
    logic vb;
    assign hb = stat_flags[0];
    assign vb = stat_flags[1];

    // Window counter: cycles a dot value has been sampled unchanged.
    logic [DOT_W-1:0] prev_dot_q;
    int unsigned      hold_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_dot_q <= '0;
            hold_q     <= 0;
        end else begin
            prev_dot_q <= dot_x;
            hold_q     <= (dot_x != prev_dot_q) ? 0 : hold_q + 1;
        end
    end

    // R1
    dot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dot_x != $past(dot_x)) |-> (int'(dot_x) == (int'($past(dot_x)) + 1) % TOTAL_DOTS));

    // R1
    dot_rate_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q <= CLKS_PER_DOT);

    // R2
    hb_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hb) |-> (int'(dot_x) == DRAW_DOTS));

    // R2
    hb_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hb) |-> (dot_x == '0) && (line_y != $past(line_y)));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        (line_y != $past(line_y)) |-> (int'(line_y) == (int'($past(line_y)) + 1) % FRAME_LINES));

    // R4
    vb_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vb) |-> (int'(line_y) == ACTIVE_LINES));

    // R4
    vb_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vb) |-> (int'(line_y) == FRAME_LINES - 1));

    // R9
    dma_hb_chk: assert property (@(posedge clk) disable iff (rst)
        dma_hblank_stb |-> hb && !vb && (int'(dot_x) == DRAW_DOTS));

    // R10
    dma_vb_chk: assert property (@(posedge clk) disable iff (rst)
        dma_vblank_stb |-> vb && (int'(line_y) == ACTIVE_LINES) && (fb_bank != $past(fb_bank)));

    // R10
    bank_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_bank != $past(fb_bank)) |-> dma_vblank_stb);

    // R13
    dma_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_hblank_stb || dma_vblank_stb) |=> !dma_hblank_stb && !dma_vblank_stb);

    for (genvar ci = 0; ci < NUM_CLIENTS; ci++) begin : g_cli_chk
        // R6
        irq_match_chk: assert property (@(posedge clk) disable iff (rst)
            irq_match[ci] |-> stat_flags[ci*3+2] && (line_y != $past(line_y)));

        // R7
        irq_hb_chk: assert property (@(posedge clk) disable iff (rst)
            irq_hblank[ci] |-> stat_flags[ci*3] && (int'(dot_x) == DRAW_DOTS));

        // R8
        irq_vb_chk: assert property (@(posedge clk) disable iff (rst)
            irq_vblank[ci] |-> stat_flags[ci*3+1] && (int'(line_y) == ACTIVE_LINES));

        // R13
        irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            (irq_hblank[ci] || irq_vblank[ci] || irq_match[ci]) |=>
                !irq_hblank[ci] && !irq_vblank[ci] && !irq_match[ci]);
    end
endmodule

bind disp_timing_gen dt_checker #(
    .CLKS_PER_DOT (CLKS_PER_DOT),
    .DRAW_DOTS    (DRAW_DOTS),
    .BLANK_DOTS   (BLANK_DOTS),
    .FRAME_LINES  (FRAME_LINES),
    .ACTIVE_LINES (ACTIVE_LINES),
    .NUM_CLIENTS  (NUM_CLIENTS),
    .DOT_W        (DOT_W),
    .LINE_W       (LINE_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .dot_x          (dot_x),
    .line_y         (line_y),
    .stat_flags     (stat_flags),
    .irq_hblank     (irq_hblank),
    .irq_vblank     (irq_vblank),
    .irq_match      (irq_match),
    .dma_hblank_stb (dma_hblank_stb),
    .dma_vblank_stb (dma_vblank_stb),
    .fb_bank        (fb_bank)
);

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
module sim_disp_timing_gen;
    localparam int CPD   = 2;
    localparam int DRAW  = 8;
    localparam int BLANK = 4;
    localparam int TOT   = DRAW + BLANK;
    localparam int LINES = 12;
    localparam int VIS   = 8;
    localparam int NC    = 2;
    localparam int DW    = $clog2(TOT);
    localparam int LW    = $clog2(LINES);
    localparam int LC    = CPD * TOT;
    localparam int RUN   = 4 * LINES * LC + 7;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NC-1:0]        cfg_we = '0;
    logic [NC*LW-1:0]     cfg_match = '0;
    logic [NC*3-1:0]      cfg_irq_en = '0;
    logic [DW-1:0]        dot_x;
    logic [LW-1:0]        line_y;
    logic [NC*3-1:0]      stat_flags;
    logic [NC-1:0]        irq_hblank, irq_vblank, irq_match;
    logic                 dma_hblank_stb, dma_vblank_stb, fb_bank;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    disp_timing_gen #(
        .CLKS_PER_DOT (CPD), .DRAW_DOTS (DRAW), .BLANK_DOTS (BLANK),
        .FRAME_LINES (LINES), .ACTIVE_LINES (VIS), .NUM_CLIENTS (NC)
    ) u0 (
        .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_match (cfg_match),
        .cfg_irq_en (cfg_irq_en), .dot_x (dot_x), .line_y (line_y),
        .stat_flags (stat_flags), .irq_hblank (irq_hblank), .irq_vblank (irq_vblank),
        .irq_match (irq_match), .dma_hblank_stb (dma_hblank_stb),
        .dma_vblank_stb (dma_vblank_stb), .fb_bank (fb_bank)
    );

    task automatic chk(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_dot(input int k);  return (k / CPD) % TOT;    endfunction
    function automatic int exp_line(input int k); return (k / LC) % LINES;   endfunction
    function automatic bit exp_vb(input int ln);  return (ln >= VIS) && (ln <= LINES - 2); endfunction

    // Reference configuration (what each client register holds) and pending writes.
    int       m_match [NC];
    bit [2:0] m_en    [NC];
    bit       p_we    [NC];
    int       p_match [NC];
    bit [2:0] p_en    [NC];
    bit       m_coinc [NC];
    bit       m_bank;

    task automatic drive_cfg(input int ci, input int mt, input bit [2:0] en);
        cfg_we[ci] = 1'b1;
        cfg_match[ci*LW +: LW] = LW'(mt);
        cfg_irq_en[ci*3 +: 3] = en;
        p_we[ci] = 1'b1;
        p_match[ci] = mt;
        p_en[ci] = en;
    endtask

    initial begin
        void'($urandom(32'h5A17_C0DE));
        for (int i = 0; i < NC; i++) begin
            m_match[i] = 0; m_en[i] = '0; p_we[i] = 1'b0; m_coinc[i] = 1'b0;
        end
        m_bank = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(int'(dot_x), 0, "R11 dot");
        chk(int'(line_y), 0, "R11 line");
        chk(int'(stat_flags), 0, "R11 flags");
        chk(int'({irq_hblank, irq_vblank, irq_match}), 0, "R11 irq");
        chk(int'({dma_hblank_stb, dma_vblank_stb, fb_bank}), 0, "R11 dma/bank");

        rst = 1'b0;
        // Directed: client 0 matches the first blanking line with all enables;
        // client 1 matches line 0 with hblank and match enables only (R12).
        drive_cfg(0, VIS, 3'b111);
        drive_cfg(1, 0, 3'b101);

        for (int k = 1; k <= RUN; k++) begin
            int ln, dt;
            bit hbs, lent, vb;
            @(posedge clk);
            @(negedge clk);
            ln   = exp_line(k);
            dt   = exp_dot(k);
            hbs  = (k % LC) == CPD * DRAW;
            lent = (k % LC) == 0;
            vb   = exp_vb(ln);

            if (k == 1) begin
                // R11: first cycle after reset, before any event
                chk(int'(stat_flags), 0, "R11 flags after release");
            end
            chk(int'(dot_x), dt, "R1 dot position");
            chk(int'(line_y), ln, "R3 line number");
            for (int i = 0; i < NC; i++) begin
                chk(int'(stat_flags[i*3]),   int'(dt >= DRAW), "R2 hblank flag");
                chk(int'(stat_flags[i*3+1]), int'(vb), "R4 vblank flag");
            end

            if (lent && ln == VIS) m_bank = ~m_bank;
            for (int i = 0; i < NC; i++) begin
                bit eq;
                eq = lent && (ln == m_match[i]);
                if (lent) m_coinc[i] = eq;
                chk(int'(stat_flags[i*3+2]), int'(m_coinc[i]), "R5 coincidence flag");
                chk(int'(irq_match[i]), int'(eq && m_en[i][2]), "R6 line-match irq");
                chk(int'(irq_hblank[i]), int'(hbs && m_en[i][0]), "R7 hblank irq");
                chk(int'(irq_vblank[i]), int'(lent && ln == VIS && m_en[i][1]), "R8 vblank irq");
            end
            chk(int'(dma_hblank_stb), int'(hbs && !vb), "R9 hblank dma strobe");
            chk(int'(dma_vblank_stb), int'(lent && ln == VIS), "R10 vblank dma strobe");
            chk(int'(fb_bank), int'(m_bank), "R10 bank select");
            if (k % LC == 1) begin
                // R13: strobes from the previous edge are gone
                chk(int'({irq_hblank, irq_vblank, irq_match, dma_vblank_stb}), 0, "R13 single-cycle pulse");
            end

            // Writes driven last cycle took effect at this edge (R12).
            for (int i = 0; i < NC; i++) begin
                if (p_we[i]) begin
                    m_match[i] = p_match[i];
                    m_en[i]    = p_en[i];
                end
                p_we[i] = 1'b0;
            end
            cfg_we = '0;
            for (int i = 0; i < NC; i++) begin
                if ($urandom_range(0, 40) == 0)
                    drive_cfg(i, int'($urandom_range(0, LINES - 1)), 3'($urandom_range(0, 7)));
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule